// File: doc/BRIEF.md
# Flash Write Cycle Qualifier

This block stands between the asynchronous bus strobes of a flash array (chip select, write strobe, read strobe, all active low) and the command sequencer behind them. It samples the strobes with the system clock through two-flop synchronisers. It removes short pulses from the chip-select and write-strobe lines with a width filter counted in clock cycles. It then decides whether a bus write took place. A write is the window in which both chip select and write strobe are low while the read strobe is high.

The address is taken when the later of the two strobes falls. The data is taken when the earlier of the two rises. An accepted write yields a single-cycle strobe toward the sequencer, together with the captured address and data. Two power conditions gate every write. The first is a supply-good flag, which arrives as a digital input synchronous to the clock. The second is a power-on hold-off timer that starts each time that flag rises, or at reset release while it is high. The default timer length of 1,250,000 cycles gives 10 ms at 125 MHz.

Top module: `flash_wr_qual`

## Requirements
- R1: While reset is asserted, wr_strobe is 0 and wr_addr and wr_data are all zeros.
- R2: wr_addr equals the addr_in value present when the second of ce_n/we_n goes low, whichever pin goes low second.
- R3: wr_data equals the data_in value present when the first of ce_n/we_n returns high, whichever pin rises first.
- R4: oe_n low at any point while both ce_n and we_n are low produces no wr_strobe for that cycle.
- R5: A low pulse on ce_n or we_n shorter than MIN_PULSE clock cycles is ignored and produces no write. A low pulse of MIN_PULSE cycles or longer, overlapping a held-low partner pin with oe_n high, produces exactly one write.
- R6: No wr_strobe is produced in the cycle after any cycle in which supply_ok is low.
- R7: After supply_ok rises, or after reset release with supply_ok high, no write is accepted until POR_CYCLES clock cycles have elapsed. Once they have elapsed, writes are accepted.
- R8: Each accepted write raises wr_strobe for exactly one clock cycle. wr_addr and wr_data change only in the cycle in which wr_strobe is high, and they hold their values until the next accepted write.
- R9: wr_strobe is high in the (MIN_PULSE+3)-th rising clock edge after the first strobe pin rises, counting the first edge after the change as the first, and low on the edges before and after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select pin, active low, asynchronous |
| we_n | input | 1 | Write strobe pin, active low, asynchronous |
| oe_n | input | 1 | Read strobe pin, active low, asynchronous |
| addr_in | input | AW | Address bus, held stable around the strobe edges |
| data_in | input | DW | Data bus, held stable around the strobe edges |
| supply_ok | input | 1 | Supply-good flag, synchronous to clk |
| wr_strobe | output | 1 | One-cycle pulse per accepted write |
| wr_addr | output | AW | Address of the last accepted write |
| wr_data | output | DW | Data of the last accepted write |

## Verification
A width filter that settles one cycle early or late becomes visible at once. A pulse of exactly MIN_PULSE-1 or MIN_PULSE cycles then gives the wrong number of strobes, and the strobe moves away from edge MIN_PULSE+3. If the capture points are swapped (address on the first fall, data on the last rise), the bench catches it on the very next write, because it moves the bus between the two strobe edges in all four orderings. A qualification flag that forgets an OE dip, or a hold-off counter that is too short, produces a stray strobe within one write of that stimulus.

// File: rtl/wq_pkg.sv
`timescale 1ns/1ps
package wq_pkg;

  // Counter width able to hold the value n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Rising edges from the first strobe release to the output pulse:
  // two synchroniser stages, MIN_PULSE filter cycles, one output register.
  function automatic int qual_latency(input int min_pulse);
    return min_pulse + 3;
  endfunction

  typedef struct packed {
    logic ce;
    logic we;
    logic oe;
  } pin_lvl_t;

endpackage

// File: rtl/wq_pin_filter.sv
`timescale 1ns/1ps
module wq_pin_filter #(
  parameter int MIN_PULSE = 3,
  parameter bit FILTER    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic level_o
);
  localparam int CW = wq_pkg::cnt_width(MIN_PULSE);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], pin_n};
  end

  generate
    if (FILTER) begin : g_filt
      logic          filt_q;
      logic [CW-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          filt_q <= 1'b1;
          run_q  <= '0;
        end else if (sync_q[1] != filt_q) begin
          if (run_q == CW'(MIN_PULSE - 1)) begin
            filt_q <= sync_q[1];
            run_q  <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end else begin
          run_q <= '0;
        end
      end
      assign level_o = filt_q;
    end else begin : g_plain
      assign level_o = sync_q[1];
    end
  endgenerate
endmodule

// File: rtl/wq_por_timer.sv
`timescale 1ns/1ps
module wq_por_timer #(
  parameter int POR_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic done_o
);
  localparam int CW = wq_pkg::cnt_width(POR_CYCLES);

  generate
    if (POR_CYCLES == 0) begin : g_none
      assign done_o = 1'b1;
    end else begin : g_cnt
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (!supply_ok)                cnt_q <= '0;
        else if (cnt_q != CW'(POR_CYCLES))  cnt_q <= cnt_q + 1'b1;
      end
      assign done_o = (cnt_q == CW'(POR_CYCLES));
    end
  endgenerate
endmodule

// File: rtl/wq_cycle_ctl.sv
`timescale 1ns/1ps
module wq_cycle_ctl #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wq_pkg::pin_lvl_t lvl,
  input  logic          enable,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          rise_evt,
  output logic          fall_evt,
  output logic          wr_strobe,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          active, act_q, qual_q, ok_now;
  logic [AW-1:0] cap_addr_q;

  assign active   = !lvl.ce && !lvl.we;
  assign ok_now   = lvl.oe && enable;
  assign rise_evt = active && !act_q;
  assign fall_evt = !active && act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      qual_q     <= 1'b0;
      cap_addr_q <= '0;
      wr_strobe  <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      act_q     <= active;
      wr_strobe <= 1'b0;
      if (rise_evt) begin
        cap_addr_q <= addr_in;
        qual_q     <= ok_now;
      end else if (active) begin
        qual_q <= qual_q && ok_now;
      end
      if (fall_evt && qual_q && ok_now) begin
        wr_strobe <= 1'b1;
        wr_addr   <= cap_addr_q;
        wr_data   <= data_in;
      end
    end
  end
endmodule

// File: rtl/flash_wr_qual.sv
`timescale 1ns/1ps
module flash_wr_qual #(
  parameter int AW         = 19,
  parameter int DW         = 16,
  parameter int MIN_PULSE  = 3,
  parameter int POR_CYCLES = 1250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          supply_ok,
  output logic          wr_strobe,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int NPIN = 3;

  logic [NPIN-1:0]   raw_pins;
  logic [NPIN-1:0]   lvl_pins;
  wq_pkg::pin_lvl_t  lvl;
  logic              por_done;
  logic              enable;
  logic              rise_evt;
  logic              fall_evt;

  // index 0: ce, 1: we (filtered), 2: oe (synchronised only)
  assign raw_pins = {oe_n, we_n, ce_n};

  genvar gi;
  generate
    for (gi = 0; gi < NPIN; gi++) begin : g_pin
      wq_pin_filter #(
        .MIN_PULSE (MIN_PULSE),
        .FILTER    (gi < 2)
      ) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (raw_pins[gi]),
        .level_o (lvl_pins[gi])
      );
    end
  endgenerate

  assign lvl.ce = lvl_pins[0];
  assign lvl.we = lvl_pins[1];
  assign lvl.oe = lvl_pins[2];

  wq_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .done_o    (por_done)
  );

  assign enable = supply_ok && por_done;

  wq_cycle_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl       (lvl),
    .enable    (enable),
    .addr_in   (addr_in),
    .data_in   (data_in),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .wr_strobe (wr_strobe),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );
endmodule

// File: rtl/wq_checker.sv
`timescale 1ns/1ps
module wq_checker #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          por_done,
  input logic          fall_evt,
  input logic          wr_strobe,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data
);
  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  p_hold_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> $stable(wr_addr));

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> $stable(wr_data));

  p_supply_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !wr_strobe);

  p_por_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |=> !wr_strobe);

  p_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(fall_evt));
endmodule

bind flash_wr_qual wq_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .por_done  (por_done),
  .fall_evt  (fall_evt),
  .wr_strobe (wr_strobe),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/sim_flash_wr_qual.sv
`timescale 1ns/1ps
module sim_flash_wr_qual;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int MP  = 3;
  localparam int POR = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic          supply_ok = 1'b1;
  logic          wr_strobe;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int n_chk = 0, n_fail = 0, nstb = 0;
  logic [AW-1:0] la = '0;
  logic [DW-1:0] ld = '0;

  flash_wr_qual #(.AW(AW), .DW(DW), .MIN_PULSE(MP), .POR_CYCLES(POR)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr_in(addr_in), .data_in(data_in), .supply_ok(supply_ok),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (wr_strobe) begin
    nstb++;
    la = wr_addr;
    ld = wr_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // ce_fst: chip select falls first; ce_rise: chip select rises first
  task automatic wr(input bit ce_fst, input bit ce_rise,
                    input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr_in = ~a; data_in = ~d;
    go(1);
    if (ce_fst) ce_n = 1'b0; else we_n = 1'b0;
    go(10);
    addr_in = a;
    go(1);
    if (ce_fst) we_n = 1'b0; else ce_n = 1'b0;
    go(10);
    addr_in = a ^ 8'h5a; data_in = d;
    go(1);
    if (ce_rise) ce_n = 1'b1; else we_n = 1'b1;
    go(10);
    data_in = ~d;
    if (ce_rise) we_n = 1'b1; else ce_n = 1'b1;
    go(20);
  endtask

  // hold one pin low, pulse the other low for w cycles
  task automatic pulse(input bit on_ce, input int w);
    if (on_ce) we_n = 1'b0; else ce_n = 1'b0;
    go(10);
    if (on_ce) ce_n = 1'b0; else we_n = 1'b0;
    go(w);
    if (on_ce) ce_n = 1'b1; else we_n = 1'b1;
    go(20);
    ce_n = 1'b1; we_n = 1'b1;
    go(20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int b;
    go(5);
    // R1: reset state
    chk(wr_strobe == 1'b0, "R1 strobe", wr_strobe, 0);
    chk(wr_addr == '0, "R1 addr", wr_addr, 0);
    chk(wr_data == '0, "R1 data", wr_data, 0);
    rst_n = 1'b1;
    go(POR + 20);

    // R2 R3 R8: every edge ordering with several bus values
    for (int fc = 0; fc < 2; fc++)
      for (int rc = 0; rc < 2; rc++)
        for (int k = 0; k < 3; k++) begin
          logic [AW-1:0] a;
          logic [DW-1:0] d;
          a = AW'(17 * k + 40 * fc + 90 * rc + 3);
          d = DW'(a * 7 + 1);
          b = nstb;
          wr(fc[0], rc[0], a, d);
          chk(nstb == b + 1, "R8 one strobe", nstb - b, 1);
          chk(la == a, "R2 addr at last fall", la, a);
          chk(ld == d, "R3 data at first rise", ld, d);
        end

    // R5: pulse width sweep on both filtered pins
    for (int p = 0; p < 2; p++)
      for (int w = 1; w <= MP + 2; w++) begin
        b = nstb;
        pulse(p[0], w);
        chk(nstb - b == ((w >= MP) ? 1 : 0), "R5 pulse width", nstb - b, (w >= MP) ? 1 : 0);
      end

    // R9: exact strobe edge after first release
    ce_n = 1'b0; go(10); we_n = 1'b0; go(10);
    b = nstb;
    we_n = 1'b1;
    go(MP + 2);
    chk(wr_strobe == 1'b0, "R9 early", wr_strobe, 0);
    go(1);
    chk(wr_strobe == 1'b1, "R9 on time", wr_strobe, 1);
    go(1);
    chk(wr_strobe == 1'b0, "R9 single", wr_strobe, 0);
    chk(nstb == b + 1, "R8 count", nstb - b, 1);
    ce_n = 1'b1; go(20);

    // R4: read strobe low for the whole cycle, then only mid-window
    b = nstb;
    oe_n = 1'b0;
    wr(1'b1, 1'b1, 8'h11, 8'h22);
    oe_n = 1'b1; go(10);
    chk(nstb == b, "R4 oe held low", nstb - b, 0);
    ce_n = 1'b0; we_n = 1'b0; go(12);
    oe_n = 1'b0; go(4); oe_n = 1'b1; go(12);
    ce_n = 1'b1; we_n = 1'b1; go(20);
    chk(nstb == b, "R4 oe dip", nstb - b, 0);
    chk(la != 8'h11, "R8 addr held after blocked write", la, 0);
    wr(1'b0, 1'b0, 8'h33, 8'h44);
    chk(nstb == b + 1 && la == 8'h33 && ld == 8'h44, "R4 recovery", la, 8'h33);

    // R6: supply low
    b = nstb;
    supply_ok = 1'b0; go(5);
    wr(1'b1, 1'b0, 8'h55, 8'h66);
    chk(nstb == b, "R6 supply low", nstb - b, 0);

    // R7: hold-off after supply returns
    supply_ok = 1'b1;
    ce_n = 1'b0; we_n = 1'b0; go(8);
    ce_n = 1'b1; we_n = 1'b1; go(15);
    chk(nstb == b, "R7 within hold-off", nstb - b, 0);
    go(POR + 20);
    wr(1'b0, 1'b1, 8'h77, 8'h88);
    chk(nstb == b + 1, "R7 after hold-off", nstb - b, 1);
    chk(la == 8'h77 && ld == 8'h88, "R7 values", ld, 8'h88);

    summary();
    $finish;
  end
endmodule